// File: doc/BRIEF.md
# Byte-Stream JTAG Scan Engine

This block turns a stream of command bytes from a host into JTAG activity on one of several scan ports. The host writes 1, 2 or 4 bytes at a time into a write FIFO. Every write size feeds the same byte stream, and the engine consumes that stream one byte at a time, lowest byte first. A command begins with a header byte. The header selects either a TMS walk, which moves the target's TAP state machine, or a TDI/TDO shift of up to 128 bits. A shift can capture TDO bits into a read FIFO, and the host pops that FIFO as 32-bit words.

A port-select register connects the engine to exactly one scan port, or to none. TCK runs at a quarter of the system clock. TDI and TMS change only while TCK is low, and TDO is sampled on the rising edge of TCK. The engine pauses with TCK parked low in one case: a capture word must be stored while the read FIFO is full. A status word shows whether the engine is executing a command and how many entries wait in the write FIFO.

Top module: `jtag_scan_engine`

## Requirements
- R1: After reset, every scan-port output is 0, `status` is 0, `rd_valid` is 0 and `port_en` is 0.
- R2: A write pushes 1, 2 or 4 bytes of `wr_data` for `wr_size` codes 0, 1 and 2 respectively (code 3 acts as 4). The bytes are consumed lowest byte first.
- R3: `status[31]` is 1 while a command is executing. `status[30:28]` holds the number of write-FIFO entries (depth 4), and all other status bits are 0. A write that arrives while the write FIFO is full is dropped.
- R4: A write to the port-select register is taken only if it has at most one bit set; otherwise it is ignored. Only the selected port's TCK, TMS and TDI move, all other ports stay at 0, and TDO is taken from the selected port.
- R5: A header with bit 7 = 0 is a TMS walk with N = bits 5:0. It produces N+1 TCK cycles, and cycle i drives TMS = header bit min(i,5).
- R6: In a TMS walk, header bit 6 = 1 means one extra byte follows, and cycle i drives TDI = that byte's bit min(i,7). When bit 6 is 0, no byte follows and TDI is 0.
- R7: A header with bit 7 = 1 is a shift. The next byte's bits 6:0 give the bit count minus 1, and its bit 7 is ignored. When header bit 4 = 1, ceil(count/8) data bytes follow and are shifted out LSB first on TDI. When bit 4 = 0, no data bytes are consumed and TDI is 0.
- R8: During a shift, TMS is 0 on every bit except the last, where it is 1.
- R9: TCK is high for exactly 2 clocks per bit, and consecutive bits of one command are 4 clocks apart, except one extra clock after each stored capture word. TMS and TDI are stable while TCK is high.
- R10: When shift header bit 2 = 1, TDO bits are packed LSB first into 32-bit words. Each full word, and the final partial word padded with zeros, is pushed to the read FIFO. The host reads that FIFO through `rd_data`/`rd_valid`/`rd_en`.
- R11: When a capture word is ready and the read FIFO (4 words) is full, the engine waits with TCK low and `status[31]` = 1 until the host frees space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push one write into the write FIFO |
| wr_size | input | 2 | Write size code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| wr_data | input | 32 | Write data, lowest byte consumed first |
| psel_wr | input | 1 | Write strobe for the port-select register |
| psel_data | input | 8 | New port-select value, one bit per port |
| rd_en | input | 1 | Pop one word from the read FIFO |
| rd_data | output | 32 | Head word of the read FIFO |
| rd_valid | output | 1 | Read FIFO holds at least one word |
| status | output | 32 | Bit 31 busy, bits 30:28 write-FIFO entries |
| port_en | output | 8 | Current port selection |
| jtag_tck | output | 8 | TCK per port |
| jtag_tms | output | 8 | TMS per port |
| jtag_tdi | output | 8 | TDI per port |
| jtag_tdo | input | 8 | TDO per port |

## Verification
Some behaviour is checked by assertions on every clock. They cover the TCK high time, the stability of TMS and TDI while TCK is high, TMS staying low inside a shift, quiet pins when idle, a parked TCK while a capture word waits for space, the FIFOs refusing to overflow or underflow, and the one-hot port selection. Other behaviour can only be shown by the bench scenarios. These include the decoding of each header form, the byte order across the three write sizes, the exact bit sequences for TMS and TDI, the packing of captured TDO into words, the status value with a full write FIFO, and the stall and resume when the read FIFO is full.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int HDR_MODE_BIT    = 7;
    localparam int HDR_TMS_PL_BIT  = 6;
    localparam int HDR_SH_PL_BIT   = 4;
    localparam int HDR_CAPTURE_BIT = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEN,
        S_TMSB,
        S_LOAD,
        S_RUN,
        S_PUSH
    } seq_state_e;

    typedef struct packed {
        seq_state_e  st;
        logic [1:0]  ph;
        logic        tdi_mode;
        logic        capture;
        logic        payload;
        logic [6:0]  last;
        logic [7:0]  cnt;
        logic [7:0]  sh;
        logic        tck;
        logic        tms;
        logic        tdi;
        logic [31:0] cap;
        logic [4:0]  capn;
    } seq_t;

endpackage

// File: rtl/scan_fifo.sv
module scan_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_d, wp_q, rp_d, rp_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_push = push && (cnt_q != CW'(DEPTH));
        do_pop  = pop && (cnt_q != '0);
        wp_d    = do_push ? bump(wp_q) : wp_q;
        rp_d    = do_pop ? bump(rp_q) : rp_q;
        cnt_d   = cnt_q + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            wp_q  <= wp_d;
            rp_q  <= rp_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end

    assign dout  = mem[rp_q];
    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign count = cnt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> $stable(count)); // R10

endmodule

// File: rtl/scan_unpack.sv
module scan_unpack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ent_valid,
    input  logic [1:0]  ent_size,
    input  logic [31:0] ent_data,
    output logic        ent_pop,
    output logic        byte_valid,
    output logic [7:0]  byte_data,
    input  logic        byte_take
);

    logic [1:0] idx_d, idx_q;
    logic [1:0] last_idx;

    always_comb begin
        case (ent_size)
            2'd0:    last_idx = 2'd0;
            2'd1:    last_idx = 2'd1;
            default: last_idx = 2'd3;
        endcase
        byte_valid = ent_valid;
        byte_data  = ent_data[{idx_q, 3'b000} +: 8];
        ent_pop    = byte_take && ent_valid && (idx_q == last_idx);
        idx_d      = idx_q;
        if (byte_take && ent_valid) idx_d = (idx_q == last_idx) ? 2'd0 : idx_q + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> (idx_q <= last_idx)); // R2

endmodule

// File: rtl/scan_seq.sv
module scan_seq
    import scan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    output logic        byte_take,
    input  logic        tdo,
    output logic        tck,
    output logic        tms,
    output logic        tdi,
    output logic        busy,
    input  logic        rf_full,
    output logic        rf_push,
    output logic [31:0] rf_data
);

    seq_t d, q;
    logic [2:0] tms_idx, tdi_idx;
    logic [7:0] src;
    logic       need_byte, last_bit;

    always_comb begin
        d         = q;
        byte_take = 1'b0;
        rf_push   = 1'b0;
        tms_idx   = (q.cnt >= 8'd5) ? 3'd5 : q.cnt[2:0];
        tdi_idx   = (q.cnt >= 8'd7) ? 3'd7 : q.cnt[2:0];
        last_bit  = (q.cnt[6:0] == q.last);
        need_byte = q.payload && (q.cnt[2:0] == 3'd0);
        src       = need_byte ? byte_data : q.sh;
        case (q.st)
            S_IDLE: begin
                d.tms = 1'b0;
                d.tdi = 1'b0;
                if (byte_valid) begin
                    byte_take = 1'b1;
                    d.cnt  = '0;
                    d.capn = '0;
                    d.cap  = '0;
                    d.sh   = '0;
                    if (!byte_data[HDR_MODE_BIT]) begin
                        d.tdi_mode = 1'b0;
                        d.capture  = 1'b0;
                        d.last     = {1'b0, byte_data[5:0]};
                        d.payload  = byte_data[HDR_TMS_PL_BIT];
                        d.st       = byte_data[HDR_TMS_PL_BIT] ? S_TMSB : S_LOAD;
                    end else begin
                        d.tdi_mode = 1'b1;
                        d.capture  = byte_data[HDR_CAPTURE_BIT];
                        d.payload  = byte_data[HDR_SH_PL_BIT];
                        d.st       = S_LEN;
                    end
                end
            end
            S_TMSB: begin
                if (byte_valid) begin
                    byte_take = 1'b1;
                    d.sh      = byte_data;
                    d.st      = S_LOAD;
                end
            end
            S_LEN: begin
                if (byte_valid) begin
                    byte_take = 1'b1;
                    d.last    = byte_data[6:0];
                    d.st      = S_LOAD;
                end
            end
            S_LOAD: begin
                if (q.tdi_mode) begin
                    if (!(need_byte && !byte_valid)) begin
                        byte_take = need_byte;
                        d.tdi = q.payload & src[0];
                        d.sh  = src >> 1;
                        d.tms = last_bit;
                        d.ph  = 2'd1;
                        d.st  = S_RUN;
                    end
                end else begin
                    d.tms = q.last[tms_idx];
                    d.tdi = q.sh[tdi_idx];
                    d.ph  = 2'd1;
                    d.st  = S_RUN;
                end
            end
            S_RUN: begin
                case (q.ph)
                    2'd1: begin
                        d.ph  = 2'd2;
                        d.tck = 1'b1;
                        if (q.tdi_mode && q.capture) d.cap[q.capn] = tdo;
                    end
                    2'd2: d.ph = 2'd3;
                    default: begin
                        d.tck = 1'b0;
                        d.ph  = 2'd0;
                        d.cnt = q.cnt + 8'd1;
                        if (q.tdi_mode && q.capture) begin
                            d.capn = q.capn + 5'd1;
                            d.st   = (q.capn == 5'd31 || last_bit) ? S_PUSH : S_LOAD;
                        end else begin
                            d.st   = last_bit ? S_IDLE : S_LOAD;
                        end
                    end
                endcase
            end
            S_PUSH: begin
                if (!rf_full) begin
                    rf_push = 1'b1;
                    d.cap   = '0;
                    d.capn  = '0;
                    d.st    = (q.cnt > {1'b0, q.last}) ? S_IDLE : S_LOAD;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign tck     = q.tck;
    assign tms     = q.tms;
    assign tdi     = q.tdi;
    assign busy    = (q.st != S_IDLE);
    assign rf_data = q.cap;

    AST_TCK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck) |=> tck); // R9
    AST_PINS_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tck |=> ($stable(tms) && $stable(tdi))); // R9
    AST_SHIFT_TMS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tck) && q.tdi_mode && (q.cnt[6:0] != q.last)) |-> !tms); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck); // R3
    AST_PARK_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_PUSH && rf_full) |=> (!tck && busy)); // R11

endmodule

// File: rtl/jtag_scan_engine.sv
module jtag_scan_engine #(
    parameter int NUM_PORTS = 8,
    parameter int WF_DEPTH  = 4,
    parameter int RF_DEPTH  = 4,
    localparam int WCW      = $clog2(WF_DEPTH + 1),
    localparam int RCW      = $clog2(RF_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_size,
    input  logic [31:0]          wr_data,
    input  logic                 psel_wr,
    input  logic [NUM_PORTS-1:0] psel_data,
    input  logic                 rd_en,
    output logic [31:0]          rd_data,
    output logic                 rd_valid,
    output logic [31:0]          status,
    output logic [NUM_PORTS-1:0] port_en,
    output logic [NUM_PORTS-1:0] jtag_tck,
    output logic [NUM_PORTS-1:0] jtag_tms,
    output logic [NUM_PORTS-1:0] jtag_tdi,
    input  logic [NUM_PORTS-1:0] jtag_tdo
);

    logic [NUM_PORTS-1:0] pen_d, pen_q;
    logic [33:0]          wf_dout;
    logic                 wf_full, wf_empty, wf_pop;
    logic [WCW-1:0]       wf_count;
    logic                 rf_full, rf_empty, rf_push;
    logic [RCW-1:0]       rf_count;
    logic [31:0]          rf_din;
    logic                 byte_valid, byte_take;
    logic [7:0]           byte_data;
    logic                 tck, tms, tdi, tdo_sel, busy;

    always_comb begin
        pen_d = pen_q;
        if (psel_wr && ($countones(psel_data) <= 1)) pen_d = psel_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pen_q <= '0;
        else        pen_q <= pen_d;
    end

    scan_fifo #(.W(34), .DEPTH(WF_DEPTH)) u_wfifo (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .din({wr_size, wr_data}),
        .pop(wf_pop), .dout(wf_dout), .full(wf_full), .empty(wf_empty),
        .count(wf_count)
    );

    scan_unpack u_unpack (
        .clk(clk), .rst_n(rst_n), .ent_valid(!wf_empty), .ent_size(wf_dout[33:32]),
        .ent_data(wf_dout[31:0]), .ent_pop(wf_pop), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_take(byte_take)
    );

    scan_seq u_seq (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_take(byte_take), .tdo(tdo_sel), .tck(tck), .tms(tms), .tdi(tdi),
        .busy(busy), .rf_full(rf_full), .rf_push(rf_push), .rf_data(rf_din)
    );

    scan_fifo #(.W(32), .DEPTH(RF_DEPTH)) u_rfifo (
        .clk(clk), .rst_n(rst_n), .push(rf_push), .din(rf_din),
        .pop(rd_en), .dout(rd_data), .full(rf_full), .empty(rf_empty),
        .count(rf_count)
    );

    assign tdo_sel  = |(jtag_tdo & pen_q);
    assign rd_valid = !rf_empty;
    assign port_en  = pen_q;
    assign status   = {busy, 3'(wf_count), 28'd0};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign jtag_tck[p] = pen_q[p] & tck;
        assign jtag_tms[p] = pen_q[p] & tms;
        assign jtag_tdi[p] = pen_q[p] & tdi;
    end

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_en)); // R4
    AST_WF_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wf_full && !wf_pop) |=> (status[30:28] == 3'(WF_DEPTH))); // R3

endmodule

// File: tb/jtag_scan_engine_bench.sv
module jtag_scan_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_size = '0;
    logic [31:0]   wr_data = '0;
    logic          psel_wr = 1'b0;
    logic [NP-1:0] psel_data = '0;
    logic          rd_en = 1'b0;
    logic [31:0]   rd_data, status;
    logic          rd_valid;
    logic [NP-1:0] port_en, jtag_tck, jtag_tms, jtag_tdi, jtag_tdo;

    always #(CLK_PERIOD/2) clk = ~clk;

    jtag_scan_engine u_jtag_scan_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size), .wr_data(wr_data),
        .psel_wr(psel_wr), .psel_data(psel_data), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .status(status), .port_en(port_en), .jtag_tck(jtag_tck),
        .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi), .jtag_tdo(jtag_tdo)
    );

    typedef struct { bit tms; bit tdi; bit cont; string req; } bit_t;
    bit_t        sq[$];
    logic [31:0] rq[$];
    int checks = 0, fails = 0;
    int port = 3;
    int rise_cnt = 0, since_rise = 100, hi_len = 0;
    bit prev_tck = 0, rise_tms = 0, rise_tdi = 0, tdo_val = 0;

    function automatic bit pat(int k);
        return ((k * 7 + 3) % 5) < 2;
    endfunction

    always_comb
        for (int i = 0; i < NP; i++) jtag_tdo[i] = (i == port) ? tdo_val : ~tdo_val;

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected bits at each rising TCK of the selected port
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit cur = jtag_tck[port];
            since_rise++;
            if (cur && !prev_tck) begin
                if (sq.size() == 0) begin
                    chk(0, "R5", "unexpected TCK", 1, 0);
                end else begin
                    automatic bit_t e = sq.pop_front();
                    chk(jtag_tms[port] == e.tms, e.req, "TMS", 32'(jtag_tms[port]), 32'(e.tms));
                    chk(jtag_tdi[port] == e.tdi, e.req, "TDI", 32'(jtag_tdi[port]), 32'(e.tdi));
                    if (e.cont) chk(since_rise == 4, "R9", "bit interval", since_rise, 4);
                end
                chk((jtag_tck & ~(NP'(1) << port)) == '0, "R4", "other port TCK",
                    32'(jtag_tck), 32'(0));
                rise_tms = jtag_tms[port];
                rise_tdi = jtag_tdi[port];
                rise_cnt++;
                tdo_val  = pat(rise_cnt);
                since_rise = 0;
            end
            if (cur && prev_tck)
                chk(jtag_tms[port] == rise_tms && jtag_tdi[port] == rise_tdi, "R9",
                    "pins moved while TCK high", {jtag_tms[port], jtag_tdi[port]},
                    {rise_tms, rise_tdi});
            if (cur) hi_len++;
            if (!cur && prev_tck) begin
                chk(hi_len == 2, "R9", "TCK high time", hi_len, 2);
                hi_len = 0;
            end
            prev_tck = cur;
        end
    end

    task automatic wr(int sz, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_size = 2'(sz); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic psel(logic [NP-1:0] v);
        @(negedge clk);
        psel_wr = 1'b1; psel_data = v;
        @(negedge clk);
        psel_wr = 1'b0;
    endtask

    task automatic exp_tms(int arg, bit pl, logic [7:0] pb, string req);
        for (int i = 0; i <= arg; i++) begin
            automatic bit_t e;
            e.tms = arg[(i > 5) ? 5 : i];
            e.tdi = pl ? pb[(i > 7) ? 7 : i] : 1'b0;
            e.cont = (i > 0);
            e.req = req;
            sq.push_back(e);
        end
    endtask

    task automatic exp_shift(int n, bit pl, logic [127:0] data, bit cap, string req);
        for (int i = 0; i < n; i++) begin
            automatic bit_t e;
            e.tms = (i == n - 1);
            e.tdi = pl ? data[i] : 1'b0;
            e.cont = (i > 0) && !(cap && (i % 32 == 0));
            e.req = req;
            sq.push_back(e);
        end
    endtask

    task automatic exp_words(int base, int n);
        for (int w = 0; w * 32 < n; w++) begin
            automatic logic [31:0] v = '0;
            for (int k = 0; k < 32; k++)
                if (w * 32 + k < n) v[k] = pat(base + w * 32 + k);
            rq.push_back(v);
        end
    endtask

    task automatic read_word(string req);
        automatic logic [31:0] e = rq.pop_front();
        automatic int guard = 0;
        while (!rd_valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(rd_valid, req, "read FIFO empty", 32'(rd_valid), 1);
        chk(rd_data == e, req, "captured word", rd_data, e);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_idle(string req);
        do @(negedge clk); while (status != 0);
        repeat (3) @(negedge clk);
        chk(sq.size() == 0, req, "expected bits left", sq.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        automatic int base;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(status == 0, "R1", "status", status, 0);
        chk(!rd_valid, "R1", "rd_valid", 32'(rd_valid), 0);
        chk(port_en == 0, "R1", "port_en", 32'(port_en), 0);
        chk(jtag_tck == 0 && jtag_tms == 0 && jtag_tdi == 0, "R1", "pins",
            {jtag_tck, jtag_tms, jtag_tdi}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: single-bit selection taken, multi-bit ignored
        psel(8'h08);
        chk(port_en == 8'h08, "R4", "port select", 32'(port_en), 32'h08);
        psel(8'h0C);
        chk(port_en == 8'h08, "R4", "multi-bit select ignored", 32'(port_en), 32'h08);

        // R5 / R2: one-byte TMS walk, arg 5
        exp_tms(5, 0, 8'h00, "R5");
        wr(0, 32'h0000_0005);
        wait_idle("R5");

        // R6 / R2: two-byte write, TMS walk with TDI byte
        exp_tms(6'h2A, 1, 8'h96, "R6");
        wr(1, 32'h0000_966A);
        wait_idle("R6");

        // R7 / R8 / R2: four-byte write, 12-bit shift with payload
        exp_shift(12, 1, 128'hABC, 0, "R7");
        wr(2, 32'h0ABC_0B90);
        wait_idle("R8");

        // R7 / R4: port 0, shift without payload, length bit 7 ignored, then 1-cycle TMS
        psel(8'h01);
        port = 0;
        exp_shift(5, 0, '0, 0, "R7");
        exp_tms(0, 0, 8'h00, "R7");
        wr(1, 32'h0000_8480);
        wr(0, 32'h0000_0000);
        wait_idle("R7");
        psel(8'h08);
        port = 3;

        // R10: 40-bit capture with payload
        base = rise_cnt;
        exp_shift(40, 1, 128'h11_2233_4455, 1, "R10");
        exp_words(base, 40);
        wr(1, 32'h0000_2794);
        wr(2, 32'h2233_4455);
        wr(0, 32'h0000_0011);
        wait_idle("R10");
        read_word("R10");
        read_word("R10");
        chk(!rd_valid, "R10", "read FIFO drained", 32'(rd_valid), 0);

        // R11: fill read FIFO with 128 bits, then an 8-bit capture stalls
        base = rise_cnt;
        exp_shift(128, 0, '0, 1, "R11");
        exp_shift(8, 0, '0, 1, "R11");
        exp_words(base, 128);
        exp_words(base + 128, 8);
        wr(1, 32'h0000_7F84);
        wr(1, 32'h0000_0784);
        repeat (700) @(negedge clk);
        chk(status[31], "R11", "busy while parked", 32'(status[31]), 1);
        chk(jtag_tck[port] == 1'b0, "R11", "TCK parked low", 32'(jtag_tck[port]), 0);
        chk(rise_cnt - base == 136, "R11", "bits before stall", rise_cnt - base, 136);
        for (int i = 0; i < 5; i++) read_word("R11");
        wait_idle("R11");

        // R3: status with full write FIFO, fifth write dropped
        exp_tms(63, 0, 8'h00, "R3");
        for (int i = 0; i < 4; i++) exp_tms(0, 0, 8'h00, "R3");
        wr(0, 32'h0000_003F);
        repeat (4) @(negedge clk);
        chk(status == 32'h8000_0000, "R3", "busy, FIFO empty", status, 32'h8000_0000);
        for (int i = 0; i < 5; i++) wr(0, 32'h0000_0000);
        chk(status == 32'hC000_0000, "R3", "busy, 4 entries", status, 32'hC000_0000);
        wait_idle("R3");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule